// File: doc/BRIEF.md
# Supervisor Interrupt Pending and Enable Registers

This block keeps one hart's supervisor-level interrupt-pending and interrupt-enable words. Supervisor software reads and writes either word through a simple CSR port. A select line chooses the word. The pending word mixes two kinds of bit. Some are latches that software owns, or that an inter-hart request may set. The others copy hardware conditions that software cannot change.

Hardware drives several inputs. A pair of strobes sets and clears the supervisor timer pending bit. A level input carries the supervisor external interrupt, and a second level input carries the user timer interrupt. A one-cycle strobe carries an interprocessor request, and it sets the supervisor software pending bit. For each interrupt class the block outputs a registered pending-and-enabled vector, which the surrounding trap logic consumes. A parameter removes every user-level bit when user interrupts are not supported.

Top module: `sv_intr_regs`

## Requirements
- R1: After reset, both words read as zero and `irq_take` is zero.
- R2: A CSR write to the pending word (csr_sel=0) sets bit 1 (supervisor software) when the written bit is 1 and clears it when the written bit is 0.
- R3: With user interrupts supported, bit 0 (user software) and bit 8 (user external) of the pending word take the written value on a pending-word write.
- R4: CSR writes leave pending bits 4, 5 and 9 unchanged, and every position other than 0, 1, 4, 5, 8 and 9 always reads zero.
- R5: A pulse on `ipi_set` sets pending bit 1 one cycle later. When that pulse meets a software write of 0 to bit 1 in the same cycle, the result is 1.
- R6: `stmr_set` sets pending bit 5 and `stmr_clr` clears it. When both are high in the same cycle, the bit is set.
- R7: Pending bit 9 equals `ext_lvl` sampled at the previous clock edge. With user interrupts supported, pending bit 4 likewise equals `utmr_lvl` sampled at the previous edge.
- R8: A CSR write to the enable word (csr_sel=1) stores the written value at bits 0, 1, 4, 5, 8 and 9. Every other enable position reads zero, and the enable word holds its value when it is not written.
- R9: `irq_take` equals the bitwise AND of the pending and enable words. It changes at the same clock edge that changes either word, so it is valid one cycle after the causing input.
- R10: With user interrupts not supported, pending bits 0, 4 and 8 and enable bits 0, 4 and 8 always read zero, whatever is written or driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | CSR write strobe |
| csr_sel | input | 1 | Word select: 0 pending, 1 enable |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | Selected word, combinational read |
| stmr_set | input | 1 | Supervisor timer interrupt raise strobe |
| stmr_clr | input | 1 | Supervisor timer interrupt clear strobe |
| ext_lvl | input | 1 | Supervisor external interrupt level |
| utmr_lvl | input | 1 | User timer interrupt level |
| ipi_set | input | 1 | Interprocessor request strobe, sets supervisor software pending |
| irq_take | output | XLEN | Pending-and-enabled vector, registered |

## Verification
A wrong mask or a stuck latch in this block shows at the ports as a wrong `csr_rdata` on the first read after the write or strobe that should have changed it. The same error shows as a wrong `irq_take` one cycle after that cause, with no further delay. The register paths are one flop deep. A lost interprocessor request or a timer bit that software could clear is therefore visible at the next cycle, and a collision between a strobe and a write can be settled by reading back straight away. A full sweep of the writable field shows every masking error. The hardware strobes and levels, driven one at a time and in collision, show the priority errors.

// File: rtl/sv_intr_pkg.sv
package sv_intr_pkg;
   localparam int MAP_BITS = 10;
   localparam int B_USIP   = 0;
   localparam int B_SSIP   = 1;
   localparam int B_UTIP   = 4;
   localparam int B_STIP   = 5;
   localparam int B_UEIP   = 8;
   localparam int B_SEIP   = 9;

   typedef enum logic {SEL_PEND = 1'b0, SEL_EN = 1'b1} csr_sel_e;

   // pending bits that a CSR write may change
   function automatic logic [MAP_BITS-1:0] pend_sw_mask(input bit user);
      logic [MAP_BITS-1:0] m;
      m = '0;
      m[B_SSIP] = 1'b1;
      m[B_USIP] = user;
      m[B_UEIP] = user;
      return m;
   endfunction

   // enable bits that exist
   function automatic logic [MAP_BITS-1:0] en_mask(input bit user);
      logic [MAP_BITS-1:0] m;
      m = '0;
      m[B_SSIP] = 1'b1;
      m[B_STIP] = 1'b1;
      m[B_SEIP] = 1'b1;
      m[B_USIP] = user;
      m[B_UTIP] = user;
      m[B_UEIP] = user;
      return m;
   endfunction
endpackage

// File: rtl/sv_intr_pend.sv
module sv_intr_pend
   import sv_intr_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int USER_INTR = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sw_we,
   input  logic [XLEN-1:0] sw_data,
   input  logic            ipi_set,
   input  logic            stmr_set,
   input  logic            stmr_clr,
   input  logic            ext_lvl,
   input  logic            utmr_lvl,
   output logic [XLEN-1:0] pend_d,
   output logic [XLEN-1:0] pend_q
);
   localparam logic [XLEN-1:0] WMASK = XLEN'(pend_sw_mask(USER_INTR != 0));

   logic utip_src;

   generate
      if (USER_INTR != 0) begin : g_user
         assign utip_src = utmr_lvl;
      end else begin : g_nouser
         logic unused_utmr;
         assign unused_utmr = utmr_lvl;
         assign utip_src    = 1'b0;
      end
   endgenerate

   always_comb begin
      pend_d = pend_q & WMASK;
      if (sw_we) pend_d = sw_data & WMASK;
      if (ipi_set) pend_d[B_SSIP] = 1'b1;            // request beats a write of 0
      if (stmr_set) pend_d[B_STIP] = 1'b1;           // raise beats clear
      else if (!stmr_clr) pend_d[B_STIP] = pend_q[B_STIP];
      else pend_d[B_STIP] = 1'b0;
      pend_d[B_SEIP] = ext_lvl;
      pend_d[B_UTIP] = utip_src;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
   end

   p_ipi_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ipi_set |=> pend_q[B_SSIP]);
   p_ssip_sw_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_we && !ipi_set) |=> pend_q[B_SSIP] == $past(sw_data[B_SSIP]));
   p_stip_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!stmr_set && !stmr_clr) |=> $stable(pend_q[B_STIP]));
   p_stip_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stmr_set |=> pend_q[B_STIP]);
   p_stip_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stmr_clr && !stmr_set) |=> !pend_q[B_STIP]);
   p_seip_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> pend_q[B_SEIP] == $past(ext_lvl));
endmodule

// File: rtl/sv_intr_en.sv
module sv_intr_en
   import sv_intr_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int USER_INTR = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sw_we,
   input  logic [XLEN-1:0] sw_data,
   output logic [XLEN-1:0] en_d,
   output logic [XLEN-1:0] en_q
);
   localparam logic [XLEN-1:0] EMASK = XLEN'(en_mask(USER_INTR != 0));

   always_comb en_d = sw_we ? (sw_data & EMASK) : en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= en_d;
   end

   p_en_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sw_we |=> en_q == ($past(sw_data) & EMASK));
   p_en_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_we |=> $stable(en_q));
endmodule

// File: rtl/sv_intr_gate.sv
module sv_intr_gate #(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [XLEN-1:0] pend_d,
   input  logic [XLEN-1:0] en_d,
   output logic [XLEN-1:0] take_q
);
   // registered from next-state values so it moves with the words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) take_q <= '0;
      else        take_q <= pend_d & en_d;
   end
endmodule

// File: rtl/sv_intr_regs.sv
module sv_intr_regs
   import sv_intr_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int USER_INTR = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            csr_we,
   input  logic            csr_sel,
   input  logic [XLEN-1:0] csr_wdata,
   output logic [XLEN-1:0] csr_rdata,
   input  logic            stmr_set,
   input  logic            stmr_clr,
   input  logic            ext_lvl,
   input  logic            utmr_lvl,
   input  logic            ipi_set,
   output logic [XLEN-1:0] irq_take
);
   generate
      if (XLEN < MAP_BITS) begin : g_bad_xlen
         $error("sv_intr_regs: XLEN must be at least %0d", MAP_BITS);
      end
      if (USER_INTR != 0 && USER_INTR != 1) begin : g_bad_user
         $error("sv_intr_regs: USER_INTR must be 0 or 1");
      end
   endgenerate

   csr_sel_e        sel;
   logic            we_pend, we_en;
   logic [XLEN-1:0] pend_d, pend_q, en_d, en_q;

   assign sel     = csr_sel_e'(csr_sel);
   assign we_pend = csr_we && (sel == SEL_PEND);
   assign we_en   = csr_we && (sel == SEL_EN);

   sv_intr_pend #(.XLEN(XLEN), .USER_INTR(USER_INTR)) u_pend (
      .clk(clk), .rst_n(rst_n), .sw_we(we_pend), .sw_data(csr_wdata),
      .ipi_set(ipi_set), .stmr_set(stmr_set), .stmr_clr(stmr_clr),
      .ext_lvl(ext_lvl), .utmr_lvl(utmr_lvl),
      .pend_d(pend_d), .pend_q(pend_q)
   );

   sv_intr_en #(.XLEN(XLEN), .USER_INTR(USER_INTR)) u_en (
      .clk(clk), .rst_n(rst_n), .sw_we(we_en), .sw_data(csr_wdata),
      .en_d(en_d), .en_q(en_q)
   );

   sv_intr_gate #(.XLEN(XLEN)) u_gate (
      .clk(clk), .rst_n(rst_n), .pend_d(pend_d), .en_d(en_d), .take_q(irq_take)
   );

   assign csr_rdata = (sel == SEL_EN) ? en_q : pend_q;

   p_take_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> irq_take == (pend_q & en_q));
endmodule

// File: tb/sim_sv_intr_regs.sv
module sim_sv_intr_regs;
   localparam int CLK_PERIOD = 10;
   localparam int XLEN = 32;
   localparam logic [XLEN-1:0] PW1 = 32'h103, PW0 = 32'h002;
   localparam logic [XLEN-1:0] EM1 = 32'h333, EM0 = 32'h222;

   logic clk = 1'b0, rst_n = 1'b0;
   logic csr_we = 1'b0, csr_sel = 1'b0;
   logic [XLEN-1:0] csr_wdata = '0;
   logic stmr_set = 1'b0, stmr_clr = 1'b0, ext_lvl = 1'b0, utmr_lvl = 1'b0, ipi_set = 1'b0;
   logic [XLEN-1:0] rd0, rd1, tk0, tk1;
   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sv_intr_regs #(.XLEN(XLEN), .USER_INTR(1)) u0 (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
      .csr_rdata(rd0), .stmr_set(stmr_set), .stmr_clr(stmr_clr), .ext_lvl(ext_lvl),
      .utmr_lvl(utmr_lvl), .ipi_set(ipi_set), .irq_take(tk0));
   sv_intr_regs #(.XLEN(XLEN), .USER_INTR(0)) u1 (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
      .csr_rdata(rd1), .stmr_set(stmr_set), .stmr_clr(stmr_clr), .ext_lvl(ext_lvl),
      .utmr_lvl(utmr_lvl), .ipi_set(ipi_set), .irq_take(tk1));

   task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic s, input logic [XLEN-1:0] d);
      @(negedge clk); csr_we = 1'b1; csr_sel = s; csr_wdata = d;
      @(negedge clk); csr_we = 1'b0;
   endtask

   task automatic rd(input logic s, output logic [XLEN-1:0] r0, output logic [XLEN-1:0] r1);
      csr_sel = s; #1; r0 = rd0; r1 = rd1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD*150000);
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [XLEN-1:0] a, b;
      repeat (3) @(negedge clk);
      // R1 reset state
      rd(1'b0, a, b); chk("R1 pend", a, '0); chk("R1 pend u1", b, '0);
      rd(1'b1, a, b); chk("R1 en", a, '0);
      chk("R1 take", tk0, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 R4 R8 R9 R10 sweep of the low field with noisy upper bits
      for (int i = 0; i < 1024; i++) begin
         logic [XLEN-1:0] pd, ed;
         pd = XLEN'(i) | (XLEN'(i * 7919) << 10);
         ed = XLEN'(1023 - i) | (XLEN'(i * 131) << 10);
         wr(1'b0, pd);
         wr(1'b1, ed);
         rd(1'b0, a, b);
         chk("R3 R4 pend sweep", a, pd & PW1);
         chk("R10 pend sweep u1", b, pd & PW0);
         rd(1'b1, a, b);
         chk("R8 en sweep", a, ed & EM1);
         chk("R10 en sweep u1", b, ed & EM0);
         chk("R9 take sweep", tk0, pd & PW1 & ed & EM1);
         chk("R9 take sweep u1", tk1, pd & PW0 & ed & EM0);
      end

      // R2 set then clear of supervisor software pending
      wr(1'b1, '1);
      wr(1'b0, 32'h2);
      rd(1'b0, a, b); chk("R2 ssip set", a, 32'h2); chk("R9 ssip take", tk0, 32'h2);
      wr(1'b0, 32'h0);
      rd(1'b0, a, b); chk("R2 ssip clear", a, 32'h0);

      // R5 request strobe, alone and in collision with a write of 0
      @(negedge clk); ipi_set = 1'b1; @(negedge clk); ipi_set = 1'b0;
      rd(1'b0, a, b); chk("R5 ipi set", a, 32'h2); chk("R5 ipi set u1", b, 32'h2);
      wr(1'b0, 32'h0);
      @(negedge clk); csr_we = 1'b1; csr_sel = 1'b0; csr_wdata = 32'h0; ipi_set = 1'b1;
      @(negedge clk); csr_we = 1'b0; ipi_set = 1'b0;
      rd(1'b0, a, b); chk("R5 ipi beats write 0", a, 32'h2);
      wr(1'b0, 32'h0);

      // R6 timer strobes, R4 read-only against writes
      @(negedge clk); stmr_set = 1'b1; @(negedge clk); stmr_set = 1'b0;
      rd(1'b0, a, b); chk("R6 stip set", a, 32'h20); chk("R9 stip take", tk0, 32'h20);
      wr(1'b0, 32'h0);
      rd(1'b0, a, b); chk("R4 stip survives write 0", a, 32'h20);
      @(negedge clk); stmr_clr = 1'b1; @(negedge clk); stmr_clr = 1'b0;
      rd(1'b0, a, b); chk("R6 stip clear", a, 32'h0);
      wr(1'b0, 32'h230);
      rd(1'b0, a, b); chk("R4 ro bits ignore write 1", a, 32'h0);
      @(negedge clk); stmr_set = 1'b1; stmr_clr = 1'b1; @(negedge clk); stmr_set = 1'b0; stmr_clr = 1'b0;
      rd(1'b0, a, b); chk("R6 set beats clear", a, 32'h20); chk("R6 set beats clear u1", b, 32'h20);
      @(negedge clk); stmr_clr = 1'b1; @(negedge clk); stmr_clr = 1'b0;

      // R7 R9 level inputs follow one edge later
      @(negedge clk); ext_lvl = 1'b1; utmr_lvl = 1'b1;
      #1; chk("R9 take before edge", tk0, 32'h0);
      @(negedge clk);
      rd(1'b0, a, b); chk("R7 seip utip", a, 32'h210); chk("R10 utip absent u1", b, 32'h200);
      chk("R9 take after edge", tk0, 32'h210); chk("R9 take after edge u1", tk1, 32'h200);
      wr(1'b1, 32'h200);
      chk("R9 take mask change", tk0, 32'h200);
      @(negedge clk); ext_lvl = 1'b0; utmr_lvl = 1'b0;
      @(negedge clk);
      rd(1'b0, a, b); chk("R7 levels drop", a, 32'h0); chk("R9 take drop", tk0, 32'h0);
      rd(1'b1, a, b); chk("R8 en held", a, 32'h200);

      finish_run();
   end
endmodule